// File: doc/BRIEF.md
# Vertical Laplacian image sharpening filter

This block sharpens a raster image across lines only. Pixels arrive one per clock, in scan order, with a valid strobe. Two chained line delays line up three vertically neighbouring pixels:

- the incoming pixel `B`, from line n+1;
- the pixel one line earlier, `N`, from line n;
- the pixel two lines earlier, `A`, from line n-1.

The block forms the second difference `2N - (A + B)`, scales it by an unsigned coefficient `K`, adds the result to `N`, and clamps the sum to the pixel range. Pixels that sit next to each other along a line are never combined.

The output strobe stays low until two complete lines have entered. From then on, every accepted pixel yields exactly one corrected pixel one clock later. Idle input cycles freeze the whole pipeline. The coefficient is held constant through a frame. A new frame starts with a reset.

Top module: `vls_vertical_sharpen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_pix` become 0 on that edge.
- R2: After reset, the first 2*LINE_LEN accepted pixels produce no output. Every accepted pixel after them produces exactly one output with `out_valid` high on the clock edge that follows its acceptance.
- R3: Take the output for an accepted pixel with index p ≥ 2*LINE_LEN (counting from 0 since reset). It uses `B` = pixel p, `N` = pixel p-LINE_LEN and `A` = pixel p-2*LINE_LEN.
- R4: The output value is `N + floor((K*(2N-A-B) + 8) / 16)`, computed with signed arithmetic wide enough that nothing overflows. In a flat region (A = N = B) the output therefore equals N.
- R5: The result is clamped to 0..1023. A negative result gives 0 and a result above 1023 gives 1023.
- R6: With `coef_k` = 0, the output equals N exactly.
- R7: A cycle with `in_valid` low has no effect. It does not advance either line delay or the fill count, `out_valid` is low on the next edge, and `out_pix` keeps its last value.
- R8: `coef_k` is unsigned with 4 integer bits and 4 fraction bits. 0x10 means 1.0, 0x18 means 1.5, and 0xFF means 15.9375.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset; begins a frame |
| in_valid | input | 1 | Incoming pixel strobe |
| in_pix | input | 10 | Incoming pixel (line n+1 value) |
| coef_k | input | 8 | Sharpening coefficient, unsigned 4.4 |
| out_valid | output | 1 | Corrected pixel strobe |
| out_pix | output | 10 | Corrected pixel |

## Verification
A corrupted line-delay pointer or a wrong delay length would pair a pixel with the wrong neighbours. The first output after the fill phase would then be wrong, and every later output would stay wrong as long as the image is not flat. A fill counter that is off by one moves the first strobe one cycle early or late, which shows at the very first output. Arithmetic faults in rounding, sign extension or clamping show up in the first output that hits a fractional coefficient or a rail. Frames are therefore built with distinct values per line and position, with both rails and with fractional coefficients.

// File: rtl/vls_pkg.sv
// Package: shared types for the vertical sharpening filter.
// Assumes nothing beyond SystemVerilog 2017 enums.
package vls_pkg;

    // Fill phase of the filter: waiting for two lines, or producing output.
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_t;

    // Rounding constant offset for a fixed-point shift by FRAC bits.
    function automatic int half_lsb(input int frac);
        return (frac > 0) ? (1 << (frac - 1)) : 0;
    endfunction

endpackage

// File: rtl/vls_line_delay.sv
// Module: vls_line_delay
// Delays a pixel stream by exactly LEN accepted pixels. It uses a circular
// buffer with one pointer: the slot under the pointer holds the pixel written
// LEN advances ago, and the same slot is overwritten when the next advance
// comes. Assumes LEN >= 2. Buffer contents are not reset; the caller must
// ignore dout until LEN pixels have been written.
module vls_line_delay #(
    parameter int W   = 10,
    parameter int LEN = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [W-1:0]  mem [LEN];
    logic [PW-1:0] ptr;

    // Oldest stored pixel is the one under the pointer.
    assign dout = mem[ptr];

    // Store the incoming pixel over the oldest one on each advance.
    always_ff @(posedge clk) begin
        if (adv) begin
            mem[ptr] <= din;
        end
    end

    // Step the pointer around the buffer on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == PW'(LEN - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // R3: the pointer must stay inside the buffer so the delay is exactly LEN.
    assert_ptr_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < PW'(LEN))
        else $error("line delay pointer out of range");

endmodule

// File: rtl/vls_fill_ctrl.sv
// Module: vls_fill_ctrl
// Counts accepted pixels after reset. It reports 'primed' once two full
// lines (2*LEN pixels) have entered, so that the taps of both line delays
// hold real data. Once primed, it stays primed until reset.
module vls_fill_ctrl
    import vls_pkg::*;
#(
    parameter int LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic primed
);
    localparam int FILL_N = 2 * LEN;
    localparam int CW     = $clog2(FILL_N);

    fill_state_t   state;
    logic [CW-1:0] cnt;

    // Advance the fill count and switch to run after the last fill pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else if (adv && state == ST_FILL) begin
            if (cnt == CW'(FILL_N - 1)) begin
                state <= ST_RUN;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Expose the run state to the output stage.
    assign primed = (state == ST_RUN);

    // R2: once running, the filter never drops back into the fill phase.
    assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN))
        else $error("fill state left run");

    // R2: the count never moves while no pixel is accepted.
    assert_fill_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(cnt) && $stable(state)))
        else $error("fill count moved without a pixel");

endmodule

// File: rtl/vls_sharpen_alu.sv
// Module: vls_sharpen_alu
// Computes N + K*(2N - (A+B)), where K is unsigned fixed point with KF
// fraction bits. The product is rounded half-up on the fraction and the sum
// is clamped to 0..2^W-1. The result is registered when 'en' is high and
// held otherwise. Intermediate widths are sized so that no term overflows.
module vls_sharpen_alu
    import vls_pkg::*;
#(
    parameter int W  = 10,
    parameter int KW = 8,
    parameter int KF = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] n,
    input  logic [W-1:0] b,
    input  logic [KW-1:0] k,
    output logic [W-1:0] res_q
);
    localparam int DW = W + 3;           // holds 2N - (A+B), signed
    localparam int PW = DW + KW + 1;     // holds the signed product and sums
    localparam logic signed [PW-1:0] HALF = PW'(half_lsb(KF));
    localparam logic signed [PW-1:0] MAXV = PW'((1 << W) - 1);

    logic signed [DW-1:0] twice_n;
    logic signed [DW-1:0] sum_ab;
    logic signed [DW-1:0] diff;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [PW-1:0] total;
    logic        [W-1:0]  clamped;

    // Form the second difference, scale it, round it and add it to the centre.
    always_comb begin
        twice_n = DW'({n, 1'b0});
        sum_ab  = DW'(a) + DW'(b);
        diff    = twice_n - sum_ab;
        prod    = PW'(diff) * PW'($signed({1'b0, k}));
        scaled  = (prod + HALF) >>> KF;
        total   = scaled + PW'($signed({1'b0, n}));
    end

    // Clamp the corrected value to the pixel range.
    always_comb begin
        if (total[PW-1]) begin
            clamped = '0;
        end else if (total > MAXV) begin
            clamped = '1;
        end else begin
            clamped = total[W-1:0];
        end
    end

    // Register the corrected pixel for each accepted output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (en) begin
            res_q <= clamped;
        end
    end

    // R6: a zero coefficient passes the centre pixel through unchanged.
    assert_unity_coef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && k == '0) |=> (res_q == $past(n)))
        else $error("zero coefficient altered the centre pixel");

    // R4: a flat column yields the centre value for any coefficient.
    assert_flat_column_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a == n && b == n) |=> (res_q == $past(n)))
        else $error("flat column altered the centre pixel");

endmodule

// File: rtl/vls_vertical_sharpen.sv
// Module: vls_vertical_sharpen (top)
// Vertical-only Laplacian sharpening. Two chained line delays line up the
// lines n+1 (input), n and n-1. The arithmetic stage outputs the corrected
// centre pixel one clock after each accepted input, once two full lines have
// entered. Assumes the coefficient is constant within a frame and that a
// frame starts with reset.
module vls_vertical_sharpen #(
    parameter int PIX_W    = 10,
    parameter int LINE_LEN = 6,
    parameter int K_W      = 8,
    parameter int K_FRAC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [K_W-1:0]   coef_k,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    localparam int N_DELAYS = 2;

    logic [PIX_W-1:0] tap [N_DELAYS+1];
    logic             primed;
    logic             take;

    // Tap 0 is the incoming line; each delay produces the next older line.
    assign tap[0] = in_pix;

    // Chain the line delays; all of them advance on accepted pixels only.
    for (genvar g = 0; g < N_DELAYS; g++) begin : g_delay
        vls_line_delay #(
            .W   (PIX_W),
            .LEN (LINE_LEN)
        ) u_delay (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (in_valid),
            .din   (tap[g]),
            .dout  (tap[g+1])
        );
    end

    vls_fill_ctrl #(
        .LEN (LINE_LEN)
    ) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (in_valid),
        .primed (primed)
    );

    // An output is produced only for accepted pixels after the fill phase.
    assign take = in_valid && primed;

    vls_sharpen_alu #(
        .W  (PIX_W),
        .KW (K_W),
        .KF (K_FRAC)
    ) u_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (take),
        .a     (tap[2]),
        .n     (tap[1]),
        .b     (tap[0]),
        .k     (coef_k),
        .res_q (out_pix)
    );

    // Register the output strobe alongside the corrected pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= take;
        end
    end

    // R7: an idle input cycle yields no output and leaves the pixel held.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_pix)))
        else $error("idle cycle disturbed the output");

endmodule

// File: tb/vls_vertical_sharpen_tb.sv
// Scoreboard bench: the driver task pushes the expected pixel and the cycle
// it is due; the monitor pops and compares on each falling edge.
module vls_vertical_sharpen_tb_top;
    localparam int W = 10;
    localparam int L = 6;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_pix = '0;
    logic [KW-1:0] coef_k = '0;
    logic          out_valid;
    logic [W-1:0]  out_pix;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int seed = 12345;
    string cur_req = "R4";
    int exp_q[$];
    int due_q[$];
    int hist[$];
    logic have_last = 1'b0;
    logic [W-1:0] last_out = '0;
    logic done = 1'b0;

    vls_vertical_sharpen #(
        .PIX_W(W), .LINE_LEN(L), .K_W(KW), .K_FRAC(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .coef_k(coef_k), .out_valid(out_valid), .out_pix(out_pix)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model built from R4, R5 and R8.
    function automatic int model(input int a, input int n, input int b, input int k);
        int d, s, r;
        d = 2 * n - a - b;
        s = (d * k + 8) >>> 4;
        r = n + s;
        if (r < 0) r = 0;
        if (r > 1023) r = 1023;
        return r;
    endfunction

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 1023;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: offer one pixel and record what it must produce (R2, R3).
    task automatic drive_pix(input int p, input int k);
        int idx;
        @(negedge clk);
        idx = hist.size();
        if (idx >= 2 * L) begin
            exp_q.push_back(model(hist[idx-2*L], hist[idx-L], p, k));
            due_q.push_back(cyc + 1);
        end
        hist.push_back(p);
        in_valid = 1'b1;
        in_pix = W'(p);
        coef_k = KW'(k);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Reset, then check the R1 reset state.
    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_pix", int'(out_pix), 0);
        hist.delete();
        have_last = 1'b0;
        rst_n = 1'b1;
    endtask

    // End of frame: every post-fill pixel must have produced its output (R2).
    task automatic end_frame();
        idle(3);
        check("R2 outputs outstanding", exp_q.size(), 0);
        exp_q.delete();
        due_q.delete();
    endtask

    // Monitor: compare each strobe with the front of the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R2: actual=unexpected output %0d expected=no output", out_pix);
                end else begin
                    check({cur_req, " value"}, int'(out_pix), exp_q[0]);
                    check("R2 latency", cyc, due_q[0]);
                    void'(exp_q.pop_front());
                    void'(due_q.pop_front());
                end
                have_last = 1'b1;
                last_out = out_pix;
            end else if (have_last) begin
                // R7: the pixel is held while no strobe is given.
                check("R7 hold", int'(out_pix), int'(last_out));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Frame 1: R4 and R8, K = 1.0, mixed content.
        cur_req = "R4";
        for (int i = 0; i < 5 * L; i++) drive_pix(next_rand(), 8'h10);
        end_frame();

        // Frame 2: R6, zero coefficient returns the centre line.
        do_reset();
        cur_req = "R6";
        for (int i = 0; i < 5 * L; i++) drive_pix(next_rand(), 8'h00);
        end_frame();

        // Frame 3: R5, alternating dark and bright lines at the largest K,
        // then random lines to mix the rails.
        do_reset();
        cur_req = "R5";
        for (int ln = 0; ln < 5; ln++)
            for (int x = 0; x < L; x++) drive_pix((ln % 2) ? 1023 : 0, 8'hFF);
        for (int i = 0; i < 2 * L; i++) drive_pix(next_rand(), 8'hFF);
        end_frame();

        // Frame 4: R3 alignment with distinct values, K = 1.5, gaps for R7.
        do_reset();
        cur_req = "R3";
        for (int ln = 0; ln < 5; ln++)
            for (int x = 0; x < L; x++) begin
                drive_pix(ln * 150 + x * 11 + 100, 8'h18);
                if (x % 2 == 1) idle(2);
            end
        end_frame();

        // Frame 5: R4 flat region with the largest K gives the centre value.
        do_reset();
        cur_req = "R4 flat";
        for (int i = 0; i < 4 * L; i++) drive_pix(517, 8'hFF);
        end_frame();

        // R1 again after a frame that left a nonzero output.
        do_reset();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule